// File: doc/BRIEF.md
# Binary ALU and Status Flag Unit

This block is the data path core of a small 8-bit accumulator processor. It combines two operands under an operation select and produces a result. It holds the processor status flags (carry, zero, overflow, negative) in its own register. Each operation writes only the flags it is defined to change, and the others keep their value. Carry-in for add, subtract and rotates comes from the stored carry flag. Arithmetic is always pure binary, and there is no decimal or interrupt state.

The same register can be set or cleared one flag at a time. It can also be loaded as a whole from a status byte, to restore after a stack pull. The register is always visible as a byte, for a stack push. A 3-bit condition select picks one of eight flag tests. Its output drives both the relative branches and the absolute conditional jumps of the processor. Instruction decode, addressing, memory and the stack pointer sit outside this block.

Top module: `alu8_flags_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the status register clears, so `status_out` reads 0x00.
- R2: Add (op 1) returns a+b+C. Subtract (op 2) returns a-b-(1-C), where carry set means no borrow. Both write all four flags: C is the carry out, or no-borrow for subtract. V flags a signed result outside -128..127. Z means the result is zero, and N is result bit 7.
- R3: Compare (op 14) sets C when a>=b unsigned and Z when a==b, and sets N from bit 7 of a-b. V is unchanged and `res_wb` is low.
- R4: AND (3), OR (4), XOR (5), NOT of a (6), increment a (7), decrement a (8) and pass a (9) write the result with `res_wb` high. They update only Z and N from the result, and leave C and V unchanged.
- R5: Shift left (10) and shift right (11) fill with 0. Rotate left (12) and rotate right (13) fill with the stored carry. All four move the bit shifted out into C, update Z and N, and leave V unchanged.
- R6: Bit test (15) updates only Z, set when (a AND b) is zero. N, V and C are unchanged and `res_wb` is low.
- R7: Set carry (16) and clear carry (17) change only C. Clear overflow (18) changes only V.
- R8: Status load (19) copies N, V, Z and C from bits 7, 6, 1 and 0 of `status_in`. `status_out` always shows N, V, Z and C at those same bit positions, and bits 5..2 read 0.
- R9: With `flag_we` low, no flag changes, whatever the operation.
- R10: `cond_true` evaluates `cond_sel` against the current flags: 0 C clear, 1 C set, 2 Z clear, 3 Z set, 4 N clear, 5 N set, 6 V clear, 7 V set.
- R11: Op 0 (no operation) and the unused codes 20..31 change no flag and keep `res_wb` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 5 | Operation code, as listed in the requirements |
| a_in | input | 8 | First operand (accumulator or index register) |
| b_in | input | 8 | Second operand (memory or immediate) |
| flag_we | input | 1 | Enables the flag write at the next rising edge |
| status_in | input | 8 | Status byte for the load operation |
| cond_sel | input | 3 | Condition code for the flag test |
| result | output | 8 | Combinational result |
| res_wb | output | 1 | High when the result should be written back |
| status_out | output | 8 | Current status byte |
| cond_true | output | 1 | Selected condition holds |

## Verification
Add, subtract and compare run over every value of a, with b stepping through sixteen values that span both sign halves, and under both carry states. This separates carry from borrow and overflow from plain sign change, and it catches carry-in slips at the 0x00/0xFF edges. Unary, shift and rotate operations see every byte with carry set and with carry clear, which shows whether rotates take in the stored carry. Before each operation, the other flags are preloaded with varied patterns, so that a flag written by mistake shows up as a changed bit. All sixteen flag combinations are crossed with all eight condition codes.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and flag indices for the ALU/status unit.
// Assumes the flag vector inside the block is ordered C, Z, V, N (bit 0..3).
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SBC  = 5'd2,
        OP_AND  = 5'd3,
        OP_ORA  = 5'd4,
        OP_EOR  = 5'd5,
        OP_NOT  = 5'd6,
        OP_INC  = 5'd7,
        OP_DEC  = 5'd8,
        OP_PASS = 5'd9,
        OP_ASL  = 5'd10,
        OP_LSR  = 5'd11,
        OP_ROL  = 5'd12,
        OP_ROR  = 5'd13,
        OP_CMP  = 5'd14,
        OP_BIT  = 5'd15,
        OP_SEC  = 5'd16,
        OP_CLC  = 5'd17,
        OP_CLV  = 5'd18,
        OP_PLP  = 5'd19
    } alu_op_e;

    localparam int FLAG_N_CNT = 4;
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_V = 2;
    localparam int FLG_N = 3;

    // Bit positions of the flags inside the status byte
    localparam int STAT_W   = 8;
    localparam int SB_C     = 0;
    localparam int SB_Z     = 1;
    localparam int SB_V     = 6;
    localparam int SB_N     = 7;

endpackage

// File: rtl/alu8_adder.sv
// Module: shared binary adder for add, subtract, compare, increment, decrement.
// Subtraction is a + ~b + carry-in; compare forces carry-in to 1.
// Assumes op is one of the adder operations; other codes give a+b.
module alu8_adder
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opnd;
    logic              ci;
    logic [DATA_W:0]   wide;

    // Pick second operand and carry-in per operation
    always_comb begin
        unique case (op)
            OP_ADC:  begin opnd = b;            ci = cin;  end
            OP_SBC:  begin opnd = ~b;           ci = cin;  end
            OP_CMP:  begin opnd = ~b;           ci = 1'b1; end
            OP_INC:  begin opnd = '0;           ci = 1'b1; end
            OP_DEC:  begin opnd = '1;           ci = 1'b0; end
            default: begin opnd = b;            ci = 1'b0; end
        endcase
    end

    // One carry chain, width DATA_W+1 keeps the carry out
    always_comb begin
        wide = {1'b0, a} + {1'b0, opnd} + {{DATA_W{1'b0}}, ci};
        sum  = wide[MSB:0];
        cout = wide[DATA_W];
        ovf  = (a[MSB] == opnd[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise and shift/rotate unit.
// Rotates take the stored carry in; cout is the bit shifted out.
// Assumes only logic or shift codes are meaningful; others return a.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int MSB = DATA_W - 1;

    // Combine operands and compute shifted-out bit
    always_comb begin
        cout = cin;
        unique case (op)
            OP_AND:  res = a & b;
            OP_ORA:  res = a | b;
            OP_EOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_ASL:  begin res = {a[MSB-1:0], 1'b0}; cout = a[MSB]; end
            OP_LSR:  begin res = {1'b0, a[MSB:1]};   cout = a[0];   end
            OP_ROL:  begin res = {a[MSB-1:0], cin};  cout = a[MSB]; end
            OP_ROR:  begin res = {cin, a[MSB:1]};    cout = a[0];   end
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_status.sv
// Module: status flag register with a per-flag write mask.
// A flag loads only when the global enable and its mask bit are both high.
// Assumes synchronous active-low reset clearing every flag.
module alu8_status
    import alu8_pkg::*;
#(
    parameter int NFLAGS = FLAG_N_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [NFLAGS-1:0] mask,
    input  logic [NFLAGS-1:0] d,
    output logic [NFLAGS-1:0] q
);
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        // Hold or load one flag bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (we && mask[i])
                q[i] <= d[i];
        end
    end

endmodule

// File: rtl/alu8_cond.sv
// Module: condition evaluator for branches and conditional jumps.
// cond[2:1] picks the flag (C, Z, N, V); cond[0] high tests for set.
module alu8_cond
    import alu8_pkg::*;
(
    input  logic [FLAG_N_CNT-1:0] flags,
    input  logic [2:0]            cond,
    output logic                  hit
);
    logic f;

    // Select the flag and apply the polarity bit
    always_comb begin
        unique case (cond[2:1])
            2'd0:    f = flags[FLG_C];
            2'd1:    f = flags[FLG_Z];
            2'd2:    f = flags[FLG_N];
            default: f = flags[FLG_V];
        endcase
        hit = cond[0] ? f : ~f;
    end

endmodule

// File: rtl/alu8_flags_unit.sv
// Module: top of the binary ALU with its status register.
// Decodes the operation into a result, a write-back strobe, new flag values
// and a flag write mask. Assumes DATA_W >= 2; status byte is always 8 bits.
module alu8_flags_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        op_sel,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              flag_we,
    input  logic [STAT_W-1:0] status_in,
    input  logic [2:0]        cond_sel,
    output logic [DATA_W-1:0] result,
    output logic              res_wb,
    output logic [STAT_W-1:0] status_out,
    output logic              cond_true
);
    localparam int MSB = DATA_W - 1;
    localparam logic [FLAG_N_CNT-1:0] M_ALL = '1;
    localparam logic [FLAG_N_CNT-1:0] M_ZN  = (1 << FLG_Z) | (1 << FLG_N);
    localparam logic [FLAG_N_CNT-1:0] M_CZN = M_ZN | (1 << FLG_C);

    alu_op_e op;
    assign op = alu_op_e'(op_sel);

    logic [FLAG_N_CNT-1:0] flags_q;
    logic [FLAG_N_CNT-1:0] flags_d;
    logic [FLAG_N_CNT-1:0] flag_mask;

    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic              add_ovf;
    logic [DATA_W-1:0] log_res;
    logic              log_cout;

    logic unused_stat_bits;
    assign unused_stat_bits = ^status_in[5:2];

    alu8_adder #(.DATA_W(DATA_W)) u_adder (
        .op   (op),
        .a    (a_in),
        .b    (b_in),
        .cin  (flags_q[FLG_C]),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .op   (op),
        .a    (a_in),
        .b    (b_in),
        .cin  (flags_q[FLG_C]),
        .res  (log_res),
        .cout (log_cout)
    );

    // Decode result, write-back and flag updates per operation
    always_comb begin
        result    = '0;
        res_wb    = 1'b0;
        flag_mask = '0;
        flags_d   = flags_q;
        unique case (op)
            OP_ADC, OP_SBC: begin
                result           = add_sum;
                res_wb           = 1'b1;
                flag_mask        = M_ALL;
                flags_d[FLG_C]   = add_cout;
                flags_d[FLG_V]   = add_ovf;
                flags_d[FLG_Z]   = (add_sum == '0);
                flags_d[FLG_N]   = add_sum[MSB];
            end
            OP_CMP: begin
                result           = add_sum;
                flag_mask        = M_CZN;
                flags_d[FLG_C]   = add_cout;
                flags_d[FLG_Z]   = (add_sum == '0);
                flags_d[FLG_N]   = add_sum[MSB];
            end
            OP_INC, OP_DEC: begin
                result           = add_sum;
                res_wb           = 1'b1;
                flag_mask        = M_ZN;
                flags_d[FLG_Z]   = (add_sum == '0);
                flags_d[FLG_N]   = add_sum[MSB];
            end
            OP_AND, OP_ORA, OP_EOR, OP_NOT, OP_PASS: begin
                result           = log_res;
                res_wb           = 1'b1;
                flag_mask        = M_ZN;
                flags_d[FLG_Z]   = (log_res == '0);
                flags_d[FLG_N]   = log_res[MSB];
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                result           = log_res;
                res_wb           = 1'b1;
                flag_mask        = M_CZN;
                flags_d[FLG_C]   = log_cout;
                flags_d[FLG_Z]   = (log_res == '0);
                flags_d[FLG_N]   = log_res[MSB];
            end
            OP_BIT: begin
                flag_mask[FLG_Z] = 1'b1;
                flags_d[FLG_Z]   = ((a_in & b_in) == '0);
            end
            OP_SEC: begin
                flag_mask[FLG_C] = 1'b1;
                flags_d[FLG_C]   = 1'b1;
            end
            OP_CLC: begin
                flag_mask[FLG_C] = 1'b1;
                flags_d[FLG_C]   = 1'b0;
            end
            OP_CLV: begin
                flag_mask[FLG_V] = 1'b1;
                flags_d[FLG_V]   = 1'b0;
            end
            OP_PLP: begin
                flag_mask        = M_ALL;
                flags_d[FLG_C]   = status_in[SB_C];
                flags_d[FLG_Z]   = status_in[SB_Z];
                flags_d[FLG_V]   = status_in[SB_V];
                flags_d[FLG_N]   = status_in[SB_N];
            end
            default: begin
                result = '0;
            end
        endcase
    end

    alu8_status #(.NFLAGS(FLAG_N_CNT)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we),
        .mask  (flag_mask),
        .d     (flags_d),
        .q     (flags_q)
    );

    // Pack flags into the status byte, unused bits zero
    always_comb begin
        status_out       = '0;
        status_out[SB_C] = flags_q[FLG_C];
        status_out[SB_Z] = flags_q[FLG_Z];
        status_out[SB_V] = flags_q[FLG_V];
        status_out[SB_N] = flags_q[FLG_N];
    end

    alu8_cond u_cond (
        .flags (flags_q),
        .cond  (cond_sel),
        .hit   (cond_true)
    );

endmodule

// File: rtl/alu8_flags_chk.sv
// Module: property checker for the ALU/status unit, bound to the top.
// Observes ports only; all properties are disabled during reset.
module alu8_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] op_sel,
    input logic       flag_we,
    input logic [7:0] status_out,
    input logic [2:0] cond_sel,
    input logic       cond_true,
    input logic       res_wb
);
    // R9
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(status_out));

    // R4
    logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel >= 5'd3 && op_sel <= 5'd9)
        |=> (status_out[0] == $past(status_out[0])) && (status_out[6] == $past(status_out[6])));

    // R6
    bit_only_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 5'd15)
        |=> (status_out[7] == $past(status_out[7])) && (status_out[6] == $past(status_out[6]))
            && (status_out[0] == $past(status_out[0])));

    // R7
    sec_sets_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 5'd16) |=> status_out[0] && $stable(status_out[7:1]));

    // R8
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_out[5:2] == 4'b0000);

    // R3
    cmp_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 5'd14) |-> !res_wb);

    // R10
    cond_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd1) |-> (cond_true == status_out[0]));

    // R11
    unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 5'd20) |=> $stable(status_out));

endmodule

bind alu8_flags_unit alu8_flags_chk u_alu8_flags_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_sel     (op_sel),
    .flag_we    (flag_we),
    .status_out (status_out),
    .cond_sel   (cond_sel),
    .cond_true  (cond_true),
    .res_wb     (res_wb)
);

// File: tb/alu8_flags_unit_bench.sv
`timescale 1ns/1ps
module alu8_flags_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] a_in = '0;
    logic [7:0] b_in = '0;
    logic       flag_we = 1'b0;
    logic [7:0] status_in = '0;
    logic [2:0] cond_sel = '0;
    logic [7:0] result;
    logic       res_wb;
    logic [7:0] status_out;
    logic       cond_true;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_st = '0;

    always #2.5 clk = ~clk;

    alu8_flags_unit u_alu8_flags_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_sel     (op_sel),
        .a_in       (a_in),
        .b_in       (b_in),
        .flag_we    (flag_we),
        .status_in  (status_in),
        .cond_sel   (cond_sel),
        .result     (result),
        .res_wb     (res_wb),
        .status_out (status_out),
        .cond_true  (cond_true)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirements
    task automatic model(input logic [4:0] op, input logic [7:0] a, b, sin, st,
                         output logic [7:0] r, output logic w, output logic [7:0] ns);
        int t;
        int sv;
        logic c, z, v, n;
        c = st[0]; z = st[1]; v = st[6]; n = st[7];
        r = '0; w = 1'b0;
        case (op)
            5'd1: begin
                t = int'(a) + int'(b) + int'(c);
                sv = int'($signed(a)) + int'($signed(b)) + int'(c);
                r = t[7:0]; w = 1'b1; c = (t > 255); v = (sv > 127) || (sv < -128);
                z = (r == 0); n = r[7];
            end
            5'd2: begin
                t = int'(a) - int'(b) - (c ? 0 : 1);
                sv = int'($signed(a)) - int'($signed(b)) - (c ? 0 : 1);
                r = t[7:0]; w = 1'b1; c = (t >= 0); v = (sv > 127) || (sv < -128);
                z = (r == 0); n = r[7];
            end
            5'd14: begin
                t = int'(a) - int'(b);
                r = t[7:0]; c = (a >= b); z = (a == b); n = r[7];
            end
            5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9: begin
                case (op)
                    5'd3: r = a & b;
                    5'd4: r = a | b;
                    5'd5: r = a ^ b;
                    5'd6: r = 8'hFF - a;
                    5'd7: r = (a == 8'hFF) ? 8'h00 : a + 8'd1;
                    5'd8: r = (a == 8'h00) ? 8'hFF : a - 8'd1;
                    default: r = a;
                endcase
                w = 1'b1; z = (r == 0); n = r[7];
            end
            5'd10, 5'd11, 5'd12, 5'd13: begin
                t = int'(a);
                case (op)
                    5'd10: begin r = 8'((t * 2) % 256);                  c = a[7]; end
                    5'd11: begin r = 8'(t / 2);                          c = a[0]; end
                    5'd12: begin r = 8'((t * 2) % 256 + int'(st[0]));    c = a[7]; end
                    default: begin r = 8'(t / 2 + (st[0] ? 128 : 0));    c = a[0]; end
                endcase
                w = 1'b1; z = (r == 0); n = r[7];
            end
            5'd15: z = ((a & b) == 0);
            5'd16: c = 1'b1;
            5'd17: c = 1'b0;
            5'd18: v = 1'b0;
            5'd19: begin c = sin[0]; z = sin[1]; v = sin[6]; n = sin[7]; end
            default: ;
        endcase
        ns = {n, v, 4'b0000, z, c};
    endtask

    // Apply one operation for one clock and check result then flags
    task automatic step(input logic [4:0] op, input logic [7:0] a, b,
                        input logic we, input logic [7:0] sin, input string req);
        logic [7:0] er, es;
        logic       ew;
        @(negedge clk);
        op_sel = op; a_in = a; b_in = b; flag_we = we; status_in = sin;
        model(op, a, b, sin, exp_st, er, ew, es);
        if (!we) es = exp_st;
        #1;
        check(res_wb == ew, req, "res_wb", int'(res_wb), int'(ew));
        if (ew) check(result == er, req, "result", int'(result), int'(er));
        @(negedge clk);
        check(status_out == es, req, "status", int'(status_out), int'(es));
        exp_st = es;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(status_out == 8'h00, "R1", "reset status", int'(status_out), 0);
        rst_n = 1'b1;
        // R1: reset clears a loaded status
        step(5'd19, 8'h00, 8'h00, 1'b1, 8'hC3, "R8");
        @(negedge clk); rst_n = 1'b0; flag_we = 1'b0;
        @(negedge clk);
        check(status_out == 8'h00, "R1", "reset after load", int'(status_out), 0);
        rst_n = 1'b1; exp_st = '0;

        // R8: every status byte loads, unused bits stay zero
        for (int s = 0; s < 256; s++)
            step(5'd19, 8'h00, 8'h00, 1'b1, 8'(s), "R8");

        // R2 / R3: add, subtract, compare sweeps
        for (int op = 0; op < 3; op++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 16; bi++)
                    for (int c = 0; c < 2; c++) begin
                        logic [7:0] pre;
                        pre = {a[1], ~a[2], 4'b0000, a[3], c[0]};
                        step(5'd19, 8'h00, 8'h00, 1'b1, pre, "R8");
                        step((op == 0) ? 5'd1 : (op == 1) ? 5'd2 : 5'd14,
                             8'(a), 8'(bi * 17), 1'b1, 8'h00, (op == 2) ? "R3" : "R2");
                    end

        // R4: binary logic ops with flags preloaded
        for (int op = 3; op < 6; op++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 16; bi++) begin
                    step(5'd19, 8'h00, 8'h00, 1'b1, {a[0], ~a[0], 4'b0, a[1], ~a[0]}, "R8");
                    step(5'(op), 8'(a), 8'(bi * 17), 1'b1, 8'h00, "R4");
                end

        // R4 / R5: unary ops over all bytes and both carry values
        for (int op = 6; op < 14; op++)
            for (int a = 0; a < 256; a++)
                for (int c = 0; c < 2; c++) begin
                    step(5'd19, 8'h00, 8'h00, 1'b1, {a[2], c[0], 4'b0, ~a[2], c[0]}, "R8");
                    step(5'(op), 8'(a), 8'h5A, 1'b1, 8'h00, (op < 10) ? "R4" : "R5");
                end

        // R6: bit test touches only Z
        for (int a = 0; a < 256; a += 3)
            for (int bi = 0; bi < 16; bi++) begin
                step(5'd19, 8'h00, 8'h00, 1'b1, {~a[0], a[0], 4'b0, a[1], a[0]}, "R8");
                step(5'd15, 8'(a), 8'(bi * 17), 1'b1, 8'h00, "R6");
            end

        // R7: set/clear carry and clear overflow from all flag states
        for (int s = 0; s < 16; s++)
            for (int op = 16; op < 19; op++) begin
                step(5'd19, 8'h00, 8'h00, 1'b1, {s[3], s[2], 4'b0, s[1], s[0]}, "R8");
                step(5'(op), 8'hFF, 8'h00, 1'b1, 8'h00, "R7");
            end

        // R9: writes disabled leave flags unchanged
        step(5'd19, 8'h00, 8'h00, 1'b1, 8'h00, "R8");
        for (int op = 1; op < 20; op++) begin
            step(5'(op), 8'h80, 8'h80, 1'b0, 8'hFF, "R9");
            step(5'(op), 8'h00, 8'hFF, 1'b0, 8'hC3, "R9");
        end

        // R11: no-op and unused codes
        for (int op = 20; op < 32; op++) begin
            step(5'd19, 8'h00, 8'h00, 1'b1, (op % 2) ? 8'hC3 : 8'h00, "R8");
            step(5'(op), 8'h80, 8'h80, 1'b1, 8'h00, "R11");
            step(5'(op), 8'h00, 8'h00, 1'b1, 8'hFF, "R11");
        end
        step(5'd0, 8'hFF, 8'h01, 1'b1, 8'hFF, "R11");

        // R10: all conditions against all flag states
        for (int s = 0; s < 16; s++) begin
            step(5'd19, 8'h00, 8'h00, 1'b1, {s[3], s[2], 4'b0, s[1], s[0]}, "R8");
            for (int c = 0; c < 8; c++) begin
                logic f, e;
                @(negedge clk);
                flag_we = 1'b0; cond_sel = 3'(c);
                case (c / 2)
                    0: f = s[0];
                    1: f = s[1];
                    2: f = s[3];
                    default: f = s[2];
                endcase
                e = (c % 2 == 1) ? f : !f;
                #1;
                check(cond_true == e, "R10", "cond_true", int'(cond_true), int'(e));
            end
        end

        summary();
        $finish;
    end

endmodule